// File: doc/BRIEF.md
# Leading-One Normaliser

This combinational block finds the most significant set bit of a vector that is a power of two bits wide. It then moves that bit to the top position by shifting the vector left, and zeros fill the low bits that the shift empties. The position of the leading one comes from a priority stage. That stage is a ripple chain working down from the top bit. A binary encoder then turns the chain's one-hot result into an index.

The index drives the shifter directly. The shift distance is the width minus one, minus the index. An enable input gates the whole block: with it low, every output is zero. A flag reports whether a set bit was found. Typical uses are normalising a mantissa before exponent adjustment elsewhere, or stripping leading zeros to align a field.

Top module: `lead_one_norm`

## Requirements
- R1: With `en` = 1 and a non-zero `vec_in`, `lead_idx` equals the binary position of the highest set bit of `vec_in` (bit 0 is the least significant).
- R2: Priority goes to the highest index. Bits below the leading one have no effect on `lead_idx`, and the internal resolved vector has at most one bit set.
- R3: For the 8-bit case, input 8'b00101001 gives `norm_out` = 8'b10100100 and `lead_idx` = 5.
- R4: `active` is 1 exactly when `en` = 1 and at least one bit of `vec_in` is 1.
- R5: When `active` = 1, `norm_out` equals `vec_in` shifted left by (width − 1 − `lead_idx`) with zeros inserted at bit 0, so `norm_out` has its top bit set.
- R6: With `en` = 1 and `vec_in` all zeros, `active`, `lead_idx` and `norm_out` are all 0.
- R7: With `en` = 0, `active`, `lead_idx` and `norm_out` are all 0 whatever `vec_in` holds.
- R8: An input with its top bit set gives `lead_idx` = width − 1 and `norm_out` = `vec_in` (no shift). An input of only bit 0 gives `lead_idx` = 0 and a full shift of width − 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vec_in | input | 2^N_LOG2 | Vector to normalise |
| en | input | 1 | Enable; low forces all outputs to zero |
| norm_out | output | 2^N_LOG2 | Vector with its leading one moved to the top |
| lead_idx | output | N_LOG2 | Position of the leading one |
| active | output | 1 | A set bit was found while enabled |

## Verification
The hardest situation to reach is a ripple chain fault that only shows when bits below the leading one are set, since a single-bit input never exercises the kill path through lower positions. The bench sweeps every one of the 256 eight-bit inputs with the enable high, so every leading position is seen with every pattern of lower bits. It then repeats a set of inputs with the enable low. The largest shift, from a lone bit 0, and the zero shift, from a set top bit, are checked as directed cases.

// File: rtl/lon_pkg.sv
package lon_pkg;
  // Distance the vector moves left so that bit idx lands on bit width-1.
  function automatic int unsigned lon_gap(input int unsigned width, input int unsigned idx);
    return (width - 1) - idx;
  endfunction
endpackage

// File: rtl/lon_prio_chain.sv
module lon_prio_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] grant,
  output logic         none_set
);
  // carry[i+1] is high while no bit above position i is set
  logic [W:0] carry;
  assign carry[W] = 1'b1;
  for (genvar i = W - 1; i >= 0; i--) begin : g_cell
    assign grant[i] = carry[i+1] & req[i];
    assign carry[i] = carry[i+1] & ~req[i];
  end
  assign none_set = carry[0];
endmodule

// File: rtl/lon_onehot_enc.sv
module lon_onehot_enc #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  onehot,
  output logic [IW-1:0] idx
);
  for (genvar j = 0; j < IW; j++) begin : g_bit
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int i = 0; i < W; i++) begin
        if (i[j]) acc = acc | onehot[i];
      end
    end
    assign idx[j] = acc;
  end
endmodule

// File: rtl/lon_left_shift.sv
module lon_left_shift #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  din,
  input  logic [IW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [W-1:0] stage [0:IW];
  assign stage[0] = din;
  for (genvar k = 0; k < IW; k++) begin : g_stage
    assign stage[k+1] = amt[k] ? (stage[k] << (1 << k)) : stage[k];
  end
  assign dout = stage[IW];
endmodule

// File: rtl/lead_one_norm.sv
module lead_one_norm #(
  parameter int N_LOG2 = 3
) (
  input  logic [(1<<N_LOG2)-1:0] vec_in,
  input  logic                   en,
  output logic [(1<<N_LOG2)-1:0] norm_out,
  output logic [N_LOG2-1:0]      lead_idx,
  output logic                   active
);
  import lon_pkg::*;
  localparam int W  = 1 << N_LOG2;
  localparam int IW = N_LOG2;

  logic [W-1:0]  gated;
  logic [W-1:0]  onehot;
  logic          none_set;
  logic [IW-1:0] shift_amt;

  assign gated = en ? vec_in : '0;

  lon_prio_chain #(.W(W)) u_chain (
    .req(gated), .grant(onehot), .none_set(none_set)
  );

  lon_onehot_enc #(.W(W), .IW(IW)) u_enc (
    .onehot(onehot), .idx(lead_idx)
  );

  assign shift_amt = IW'(lon_gap(W, int'(lead_idx)));

  lon_left_shift #(.W(W), .IW(IW)) u_shl (
    .din(gated), .amt(shift_amt), .dout(norm_out)
  );

  assign active = ~none_set;
endmodule

// File: rtl/lon_checker.sv
module lon_checker #(
  parameter int N_LOG2 = 3
) (
  input logic [(1<<N_LOG2)-1:0] vec_in,
  input logic                   en,
  input logic [(1<<N_LOG2)-1:0] norm_out,
  input logic [N_LOG2-1:0]      lead_idx,
  input logic                   active,
  input logic [(1<<N_LOG2)-1:0] onehot,
  input logic [N_LOG2-1:0]      shift_amt
);
  localparam int W = 1 << N_LOG2;
  always_comb begin
    p_onehot_r2: assert ($onehot0(onehot));
    p_flag_r4: assert (active == (en && (vec_in != '0)));
    p_top_set_r5: assert (!active || norm_out[W-1]);
    p_shift_r5: assert (!active || ((vec_in << shift_amt) == norm_out));
    p_idx_r1: assert (!active || ((vec_in >> lead_idx) == 1));
    p_quiet_r6: assert (active || (norm_out == '0 && lead_idx == '0));
    p_disabled_r7: assert (en || (!active && norm_out == '0));
  end
endmodule

bind lead_one_norm lon_checker #(.N_LOG2(N_LOG2)) u_chk (
  .vec_in(vec_in), .en(en), .norm_out(norm_out), .lead_idx(lead_idx),
  .active(active), .onehot(onehot), .shift_amt(shift_amt)
);

// File: tb/lead_one_norm_test.sv
module lead_one_norm_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] vec_in;
  logic       en;
  logic [7:0] norm_out;
  logic [2:0] lead_idx;
  logic       active;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lead_one_norm #(.N_LOG2(3)) uut (
    .vec_in(vec_in), .en(en), .norm_out(norm_out),
    .lead_idx(lead_idx), .active(active)
  );

  // {en, input, expected norm, expected idx, expected active}
  localparam int NV = 8;
  localparam logic [20:0] VECS [NV] = '{
    {1'b1, 8'b00101001, 8'b10100100, 3'd5, 1'b1},  // R3
    {1'b1, 8'b10000000, 8'b10000000, 3'd7, 1'b1},  // R8
    {1'b1, 8'b00000001, 8'b10000000, 3'd0, 1'b1},  // R8
    {1'b1, 8'b11111111, 8'b11111111, 3'd7, 1'b1},  // R8
    {1'b1, 8'b00000000, 8'b00000000, 3'd0, 1'b0},  // R6
    {1'b0, 8'b11010110, 8'b00000000, 3'd0, 1'b0},  // R7
    {1'b1, 8'b01100000, 8'b11000000, 3'd6, 1'b1},  // R1
    {1'b1, 8'b00010111, 8'b10111000, 3'd4, 1'b1}   // R5
  };

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h (in=%b en=%0b)", req, act_v, exp_v, vec_in, en);
    end
  endtask

  task automatic apply(input logic e, input logic [7:0] v);
    @(posedge clk);
    en = e;
    vec_in = v;
    @(negedge clk);
  endtask

  task automatic model(input logic e, input logic [7:0] v,
                       output logic [7:0] n, output logic [2:0] ix, output logic a);
    n = 8'd0; ix = 3'd0; a = 1'b0;
    if (e) begin
      for (int k = 7; k >= 0; k--) begin
        if (!a && v[k]) begin
          a = 1'b1;
          ix = 3'(k);
          n = v << (7 - k);
        end
      end
    end
  endtask

  initial begin
    #2000000;
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] en_n;
    logic [2:0] en_i;
    logic       en_a;
    en = 1'b0;
    vec_in = 8'hA5;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset-time state: disabled, outputs quiet (R7)
    check("R7 reset norm", int'(norm_out), 0);
    check("R7 reset active", int'(active), 0);

    for (int t = 0; t < NV; t++) begin
      apply(VECS[t][20], VECS[t][19:12]);
      check("R1/R3/R5 table norm", int'(norm_out), int'(VECS[t][11:4]));
      check("R1/R3 table idx", int'(lead_idx), int'(VECS[t][3:1]));
      check("R4 table active", int'(active), int'(VECS[t][0]));
    end

    // exhaustive sweep, enable high: R1, R2 (lower bits vary), R4, R5
    for (int v = 0; v < 256; v++) begin
      apply(1'b1, 8'(v));
      model(1'b1, 8'(v), en_n, en_i, en_a);
      check("R5 sweep norm", int'(norm_out), int'(en_n));
      check("R2 sweep idx", int'(lead_idx), int'(en_i));
      check("R4 sweep active", int'(active), int'(en_a));
    end

    // enable low over a spread of inputs: R7
    for (int v = 1; v < 256; v += 17) begin
      apply(1'b0, 8'(v));
      check("R7 disabled norm", int'(norm_out), 0);
      check("R7 disabled idx", int'(lead_idx), 0);
      check("R7 disabled active", int'(active), 0);
    end

    // directed R2: same leading bit, different tails
    apply(1'b1, 8'b00100000);
    check("R2 tail none", int'(lead_idx), 5);
    apply(1'b1, 8'b00111111);
    check("R2 tail full", int'(lead_idx), 5);
    check("R2 tail full norm", int'(norm_out), 8'hFC);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule